// File: doc/BRIEF.md
# Core Performance Event Counter Unit

This block keeps six 32-bit event counters for a processor core. Four of them are programmable: each one counts the event named by an 8-bit selector. The other two are fixed. One counts completed instructions and the other counts cycles. Each cycle, the core drives a cycle tick, an instruction-completed strobe, a run-latch level and a problem-state (user-mode) flag. Each counter adds at most one per cycle, and only if its event is present in that cycle and no freeze control applies to it.

Software reaches every register through one port. The port has a single-cycle write strobe and a combinational read. A global control register holds the freeze controls and a 2-bit field that can take the two fixed counters out of the unit. An event-select register holds the four selectors.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, the global control register (address 6) reads 0x80000000, and every other register reads 0. Because of the freeze-all bit set at reset, no counter moves until software clears that bit.
- R2: For each programmable counter (addresses 0 to 3), selector 0x02 adds one per completed instruction and selector 0x1E adds one per cycle tick.
- R3: Counter 0 also accepts two further selectors: 0xF0 counts cycle ticks and 0xFE counts completed instructions.
- R4: Counter 3 also accepts selector 0xFA. With this selector it counts completed instructions only in cycles where the run-latch input is 1.
- R5: A selector that the counter does not recognise leaves that counter holding its value. This includes a selector that is valid only on a different counter.
- R6: The global control register has three freeze bits. Bit 31 freezes all six counters. Bit 13 freezes counter 0. Bit 12 freezes counters 1 to 5. A frozen counter holds its value.
- R7: When bits 19:18 of the global control register equal 0b11, the fixed counters (addresses 4 and 5) hold their value. In that state, a user-mode read of address 4 or 5 returns 0 and a user-mode write to either address is ignored.
- R8: Fixed counter 4 counts completed instructions and fixed counter 5 counts cycle ticks. Neither has a selector.
- R9: Counters advance by at most one per cycle and wrap from 0xFFFFFFFF to 0.
- R10: A write to a counter takes priority over an increment in the same cycle. A read returns all increments up to and including the previous clock edge.
- R11: The register addresses are: 0 to 3 for the programmable counters, 4 and 5 for the fixed counters, 6 for global control and 7 for event select. Event select holds the counter 0 selector in bits 31:24, counter 1 in 23:16, counter 2 in 15:8 and counter 3 in 7:0, and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One cycle event in this cycle |
| insn_done | input | 1 | One instruction completed in this cycle |
| run_latch | input | 1 | Run-latch qualifier level |
| user_mode | input | 1 | 1 when the access comes from problem state |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |

## Verification
The checker assumes three things about the inputs: the event inputs are sampled only at the rising edge, a write lasts exactly one cycle, and the address is steady while a read is sampled. The bench meets these by changing every input at the falling edge and by holding the event inputs low while it reads the counters back. The stall and step properties assume no write happens in the same cycle. For this reason the bench keeps its writes in separate cycles from the event cycles it checks, except for the one test where it deliberately combines a write with a tick.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int DW     = 32;
  localparam int SELW   = 8;
  localparam int NPROG  = 4;
  localparam int NFIX   = 2;
  localparam int NCNT   = NPROG + NFIX;
  localparam int AW     = 3;

  localparam logic [AW-1:0] ADDR_FIX_INSN = 3'd4;
  localparam logic [AW-1:0] ADDR_FIX_CYC  = 3'd5;
  localparam logic [AW-1:0] ADDR_GCTL     = 3'd6;
  localparam logic [AW-1:0] ADDR_EVSEL    = 3'd7;

  localparam int GC_FRZ_ALL   = 31;
  localparam int GC_EXCL_HI   = 19;
  localparam int GC_EXCL_LO   = 18;
  localparam int GC_FRZ_FIRST = 13;
  localparam int GC_FRZ_REST  = 12;

  localparam logic [DW-1:0] GCTL_RESET = 32'h8000_0000;

  localparam logic [SELW-1:0] SEL_INSN     = 8'h02;
  localparam logic [SELW-1:0] SEL_CYC      = 8'h1E;
  localparam logic [SELW-1:0] SEL_CYC_ALT  = 8'hF0;
  localparam logic [SELW-1:0] SEL_INSN_ALT = 8'hFE;
  localparam logic [SELW-1:0] SEL_INSN_RUN = 8'hFA;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_INSN,
    EV_CYC,
    EV_INSN_RUN
  } ev_kind_e;
endpackage

// File: rtl/pcu_ctrl_regs.sv
module pcu_ctrl_regs
  import pcu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_gctl,
  input  logic          wr_evsel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] gctl_q,
  output logic [DW-1:0] evsel_q
);
  logic [DW-1:0] gctl_d, evsel_d;
  logic          gctl_en, evsel_en;

  always_comb begin
    gctl_en  = wr_gctl;
    evsel_en = wr_evsel;
    gctl_d   = wdata;
    evsel_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q  <= GCTL_RESET;
      evsel_q <= '0;
    end else begin
      if (gctl_en)  gctl_q  <= gctl_d;
      if (evsel_en) evsel_q <= evsel_d;
    end
  end
endmodule

// File: rtl/pcu_event_sel.sv
module pcu_event_sel
  import pcu_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [SELW-1:0] sel,
  output ev_kind_e        kind
);
  ev_kind_e common_kind;

  always_comb begin
    unique case (sel)
      SEL_INSN: common_kind = EV_INSN;
      SEL_CYC:  common_kind = EV_CYC;
      default:  common_kind = EV_NONE;
    endcase
  end

  generate
    if (IDX == 0) begin : g_first
      always_comb begin
        if (sel == SEL_CYC_ALT)       kind = EV_CYC;
        else if (sel == SEL_INSN_ALT) kind = EV_INSN;
        else                          kind = common_kind;
      end
    end else if (IDX == NPROG-1) begin : g_last
      always_comb begin
        if (sel == SEL_INSN_RUN) kind = EV_INSN_RUN;
        else                     kind = common_kind;
      end
    end else begin : g_mid
      always_comb kind = common_kind;
    end
  endgenerate
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter
  import pcu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          inc_en,
  output logic [DW-1:0] cnt_q
);
  logic [DW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = wr_en | inc_en;
    if (wr_en) cnt_d = wdata;
    else       cnt_d = cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pcu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_tick,
  input  logic          insn_done,
  input  logic          run_latch,
  input  logic          user_mode,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  logic [DW-1:0]            gctl_q, evsel_q;
  logic [NCNT-1:0][DW-1:0]  cnt_q;
  logic [NCNT-1:0]          cnt_wr, cnt_inc;
  ev_kind_e                 kind [NCNT];
  logic                     frz_all, frz_first, frz_rest, fix_excl, fix_blocked;

  always_comb begin
    frz_all     = gctl_q[GC_FRZ_ALL];
    frz_first   = gctl_q[GC_FRZ_FIRST];
    frz_rest    = gctl_q[GC_FRZ_REST];
    fix_excl    = &gctl_q[GC_EXCL_HI:GC_EXCL_LO];
    fix_blocked = user_mode && fix_excl &&
                  (reg_addr == ADDR_FIX_INSN || reg_addr == ADDR_FIX_CYC);
  end

  pcu_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_gctl  (reg_wr && reg_addr == ADDR_GCTL),
    .wr_evsel (reg_wr && reg_addr == ADDR_EVSEL),
    .wdata    (reg_wdata),
    .gctl_q   (gctl_q),
    .evsel_q  (evsel_q)
  );

  generate
    for (genvar k = 0; k < NCNT; k++) begin : g_cnt
      localparam bit IS_FIX = (k >= NPROG);
      logic stop;

      if (!IS_FIX) begin : g_prog
        pcu_event_sel #(.IDX(k)) u_sel (
          .sel  (evsel_q[DW-1-k*SELW -: SELW]),
          .kind (kind[k])
        );
      end else if (k == NPROG) begin : g_fix_insn
        assign kind[k] = EV_INSN;
      end else begin : g_fix_cyc
        assign kind[k] = EV_CYC;
      end

      always_comb begin
        stop = frz_all || ((k == 0) ? frz_first : frz_rest) || (IS_FIX && fix_excl);
        unique case (kind[k])
          EV_INSN:     cnt_inc[k] = !stop && insn_done;
          EV_CYC:      cnt_inc[k] = !stop && cyc_tick;
          EV_INSN_RUN: cnt_inc[k] = !stop && insn_done && run_latch;
          default:     cnt_inc[k] = 1'b0;
        endcase
        cnt_wr[k] = reg_wr && reg_addr == AW'(k) && !(IS_FIX && fix_blocked);
      end

      pcu_counter u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cnt_wr[k]),
        .wdata  (reg_wdata),
        .inc_en (cnt_inc[k]),
        .cnt_q  (cnt_q[k])
      );
    end
  endgenerate

  always_comb begin
    if (fix_blocked)                reg_rdata = '0;
    else if (reg_addr == ADDR_GCTL)  reg_rdata = gctl_q;
    else if (reg_addr == ADDR_EVSEL) reg_rdata = evsel_q;
    else                             reg_rdata = cnt_q[reg_addr];
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
  import pcu_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr,
  input logic [AW-1:0]           reg_addr,
  input logic [DW-1:0]           reg_wdata,
  input logic [DW-1:0]           reg_rdata,
  input logic                    user_mode,
  input logic [DW-1:0]           gctl,
  input logic [NCNT-1:0][DW-1:0] cnt
);
  logic excl;
  assign excl = gctl[GC_EXCL_HI] && gctl[GC_EXCL_LO];

  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gctl[GC_FRZ_ALL] && !reg_wr) |=> $stable(cnt));

  assert_excl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (excl && !reg_wr) |=> ($stable(cnt[NPROG]) && $stable(cnt[NPROG+1])));

  assert_user_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && excl && (reg_addr == ADDR_FIX_INSN || reg_addr == ADDR_FIX_CYC))
      |-> reg_rdata == '0);

  generate
    for (genvar k = 0; k < NCNT; k++) begin : g_chk
      assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> (cnt[k] == $past(cnt[k]) || cnt[k] == $past(cnt[k]) + DW'(1)));

      assert_wr_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(k) && !(k >= NPROG && user_mode && excl))
          |=> cnt[k] == $past(reg_wdata));
    end
  endgenerate
endmodule

bind perf_counter_unit pcu_checker u_pcu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .user_mode (user_mode),
  .gctl      (gctl_q),
  .cnt       (cnt_q)
);

// File: tb/test_perf_counter_unit.sv
`timescale 1ns/1ps
module test_perf_counter_unit;
  logic        clk = 1'b0;
  logic        rst_n, cyc_tick, insn_done, run_latch, user_mode, reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  int          errors = 0, checks = 0;
  logic [31:0] exp_cnt [6];
  logic [31:0] v, a, b, c;

  always #2.5 clk = ~clk;

  perf_counter_unit i_perf_counter_unit (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .insn_done(insn_done),
    .run_latch(run_latch), .user_mode(user_mode), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {tick, insn, run, expected increment per counter (bit k = counter k)}
  localparam logic [8:0] VEC [6] = '{
    {3'b100, 6'b100101},
    {3'b010, 6'b010010},
    {3'b111, 6'b111111},
    {3'b011, 6'b011010},
    {3'b001, 6'b000000},
    {3'b110, 6'b110111}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] addr, output logic [31:0] val);
    reg_addr = addr;
    #0.2;
    val = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic step(input logic t, input logic i, input logic r);
    @(negedge clk);
    cyc_tick = t; insn_done = i; run_latch = r;
    @(negedge clk);
    cyc_tick = 1'b0; insn_done = 1'b0; run_latch = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cyc_tick = 0; insn_done = 0; run_latch = 0; user_mode = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(3'd6, v); check("R1 gctl reset", v, 32'h8000_0000);
    rd(3'd7, v); check("R1 evsel reset", v, 32'h0);
    for (int k = 0; k < 6; k++) begin
      rd(3'(k), v); check("R1 counter reset", v, 32'h0);
      exp_cnt[k] = 32'h0;
    end

    // R1 / R6 frozen by freeze-all
    wr(3'd7, 32'hF0_02_1E_FA);
    step(1, 1, 1); step(1, 1, 1);
    for (int k = 0; k < 6; k++) begin
      rd(3'(k), v); check("R1 R6 frozen after reset", v, 32'h0);
    end
    rd(3'd7, v); check("R11 evsel readback", v, 32'hF0_02_1E_FA);

    // R2 R3 R4 R8 table
    wr(3'd6, 32'h0);
    for (int s = 0; s < 6; s++) begin
      step(VEC[s][8], VEC[s][7], VEC[s][6]);
      for (int k = 0; k < 6; k++) begin
        exp_cnt[k] = exp_cnt[k] + 32'(VEC[s][k]);
        rd(3'(k), v); check("R2 R3 R4 R8 table", v, exp_cnt[k]);
      end
    end

    // R10 write beats increment
    @(negedge clk);
    cyc_tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1234_5678;
    @(negedge clk);
    cyc_tick = 1'b0; reg_wr = 1'b0;
    rd(3'd2, v); check("R10 write priority", v, 32'h1234_5678);
    step(1, 0, 0);
    rd(3'd2, v); check("R10 read after tick", v, 32'h1234_5679);

    // R9 wrap
    wr(3'd5, 32'hFFFF_FFFF);
    step(1, 0, 0);
    rd(3'd5, v); check("R9 wrap", v, 32'h0);

    // R6 per-counter freezes
    wr(3'd6, 32'h0000_2000);
    rd(3'd0, a); rd(3'd1, b);
    step(1, 1, 0);
    rd(3'd0, v); check("R6 bit13 holds counter 0", v, a);
    rd(3'd1, v); check("R6 bit13 spares counter 1", v, b + 1);
    wr(3'd6, 32'h0000_1000);
    rd(3'd0, a); rd(3'd1, b); rd(3'd4, c);
    step(1, 1, 0);
    rd(3'd0, v); check("R6 bit12 spares counter 0", v, a + 1);
    rd(3'd1, v); check("R6 bit12 holds counter 1", v, b);
    rd(3'd4, v); check("R6 bit12 holds fixed counter", v, c);

    // R7 fixed counters excluded
    wr(3'd6, 32'h000C_0000);
    rd(3'd4, a); rd(3'd5, b);
    step(1, 1, 0);
    rd(3'd4, v); check("R7 fixed insn held", v, a);
    rd(3'd5, v); check("R7 fixed cyc held", v, b);
    user_mode = 1'b1;
    rd(3'd5, v); check("R7 user read blocked", v, 32'h0);
    wr(3'd4, 32'h0000_ABCD);
    user_mode = 1'b0;
    rd(3'd4, v); check("R7 user write ignored", v, a);

    // R5 unrecognised selectors
    wr(3'd6, 32'h0);
    wr(3'd7, 32'hFA_F0_55_FE);
    rd(3'd0, a); rd(3'd1, b); rd(3'd2, c);
    step(1, 1, 1);
    rd(3'd0, v); check("R5 counter 0 inactive", v, a);
    rd(3'd1, v); check("R5 counter 1 inactive", v, b);
    rd(3'd2, v); check("R5 counter 2 inactive", v, c);

    // R4 run-latch gating
    wr(3'd7, 32'h0000_00FA);
    rd(3'd3, a);
    step(0, 1, 0);
    rd(3'd3, v); check("R4 run low holds", v, a);
    step(0, 1, 1);
    rd(3'd3, v); check("R4 run high counts", v, a + 1);

    // R3 alternate instruction selector on counter 0
    wr(3'd7, 32'hFE00_0000);
    rd(3'd0, a);
    step(0, 1, 0);
    rd(3'd0, v); check("R3 0xFE counts insn", v, a + 1);
    step(1, 0, 0);
    rd(3'd0, v); check("R3 0xFE ignores tick", v, a + 1);

    finish_run();
  end
endmodule